// File: doc/BRIEF.md
# Halving-Tree Partial-Sum Reducer

This block keeps a bank of partial sums in registers, one per lane, and collapses them into a single total in place. Each reduction round folds the upper half of the still-active lanes onto the lower half, with one adder per lane pair working in parallel. When the active count is odd, lane 0 first absorbs the single leftover lane in a cycle of its own. Because of this, the lane count may be any positive integer and does not need to be a power of two.

The lanes are filled in one of two ways. A write port places a value directly into a chosen lane. A serial accumulate mode instead streams input beats into the lanes in contiguous groups: each lane sums its own run of beats, starting from zero, before the tree phase begins. A start pulse launches the reduction. When the last fold completes, the block raises done for one cycle and the total is presented on the output.

Top module: `tree_red_acc`

## Requirements
- R1: After reset, busy and done are 0 and total is 0, because every lane register is cleared.
- R2: In idle, wrEn loads lane wrIdx with wrData zero-extended to the sum width. The new value replaces whatever that lane held.
- R3: After a reduction, total equals the unsigned sum of all NUM_LANES lanes. The sum width is IN_W + clog2(NUM_LANES*PART_LEN), so the result cannot overflow.
- R4: Each fold round takes one cycle. If the active count is odd and greater than 1, one extra cycle comes before the fold, in which lane 0 adds in lane (count-1). With 10 lanes the counts run 10, 5, 2, 1, and done rises 4 cycles after the edge that samples start.
- R5: busy is high from the cycle after start until the last fold. done is a single-cycle pulse in the cycle where busy has just fallen.
- R6: While busy, start, wrEn, inValid and clrLocal have no effect.
- R7: In idle, clrLocal zeroes every lane and returns the stream position to lane 0. When several idle inputs arrive in the same cycle, only one acts, in this priority order: start, then clrLocal, then wrEn, then inValid.
- R8: In idle, each inValid beat adds inData to the current stream lane. The stream moves on to the next lane after PART_LEN beats. Beats that arrive after NUM_LANES*PART_LEN beats are ignored.
- R9: An odd lane count works. With 7 lanes the steps are fix, fold to 3, fix, fold to 1, so done arrives 4 cycles after start and total is the full sum.
- R10: While idle with no start, clrLocal, wrEn or inValid, total holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Direct lane load strobe |
| wrIdx | input | IDX_W | Lane selected by a direct load |
| wrData | input | IN_W | Value for a direct load |
| clrLocal | input | 1 | Zero all lanes and restart the stream position |
| inValid | input | 1 | Serial accumulate beat strobe |
| inData | input | IN_W | Serial accumulate beat value |
| start | input | 1 | Begin the tree reduction |
| busy | output | 1 | Reduction in progress |
| done | output | 1 | One-cycle pulse when the total is ready |
| total | output | SUM_W | Lane 0, which holds the result after done |

## Verification
Loads, clears and stream beats take effect at the edge that samples them, so their effect shows up in the next reduction's total. The start pulse is sampled at one edge. busy then reads high at the next falling edge, and done together with the final total appears exactly as many edges later as the count schedule gives: 4 edges for 10 lanes and 4 edges for 7 lanes. The bench drives every input on the falling edge and samples once per falling edge after start. It records the first falling edge at which done appears and compares that edge number with the expected latency. It then checks, one falling edge later, that done has dropped and that no second pulse follows.

// File: rtl/tree_red_pkg.sv
package tree_red_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } red_state_e;

  // strobes issued by control to the lane datapath each cycle
  typedef struct packed {
    logic        clearAll;   // zero every lane
    logic        loadLane;   // overwrite lane laneSel with wrData
    logic        accumLane;  // add inData into lane laneSel
    logic        fixStep;    // lane 0 += lane laneSel
    logic        foldStep;   // lane i += lane i+foldHalf for i < foldHalf
    logic [15:0] laneSel;
    logic [15:0] foldHalf;
  } red_strobe_t;

endpackage

// File: rtl/tree_red_ctrl.sv
module tree_red_ctrl
  import tree_red_pkg::*;
#(
  parameter int NUM_LANES = 10,
  parameter int PART_LEN  = 4,
  parameter int IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             clrLocal,
  input  logic             inValid,
  input  logic             start,
  output red_strobe_t      strb,
  output logic             busy,
  output logic             done
);

  localparam int CNT_W  = $clog2(NUM_LANES + 1);
  localparam int BEAT_W = $clog2(PART_LEN + 1);
  localparam logic [CNT_W-1:0]  LANES_C   = CNT_W'(NUM_LANES);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(PART_LEN - 1);

  red_state_e        stateQ;
  logic [CNT_W-1:0]  cntQ;
  logic              fixedQ;
  logic [CNT_W-1:0]  lanePtrQ;
  logic [BEAT_W-1:0] beatQ;
  logic              doneQ;

  logic             isIdle;
  logic             oddPending;
  logic [CNT_W-1:0] halfCnt;

  assign isIdle     = (stateQ == ST_IDLE);
  assign oddPending = cntQ[0] && !fixedQ;
  assign halfCnt    = cntQ >> 1;

  always_comb begin
    strb = '0;
    if (!isIdle) begin
      if (oddPending) begin
        strb.fixStep = 1'b1;
        strb.laneSel = 16'(cntQ - CNT_W'(1));
      end else begin
        strb.foldStep = 1'b1;
        strb.foldHalf = 16'(halfCnt);
      end
    end else if (start) begin
      strb = '0;
    end else if (clrLocal) begin
      strb.clearAll = 1'b1;
    end else if (wrEn) begin
      strb.loadLane = 1'b1;
      strb.laneSel  = 16'(wrIdx);
    end else if (inValid && (lanePtrQ < LANES_C)) begin
      strb.accumLane = 1'b1;
      strb.laneSel   = 16'(lanePtrQ);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      cntQ     <= '0;
      fixedQ   <= 1'b0;
      lanePtrQ <= '0;
      beatQ    <= '0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (isIdle) begin
        if (start) begin
          if (NUM_LANES == 1) begin
            doneQ <= 1'b1;
          end else begin
            stateQ <= ST_RUN;
            cntQ   <= LANES_C;
            fixedQ <= 1'b0;
          end
        end
      end else if (oddPending) begin
        fixedQ <= 1'b1;
      end else begin
        cntQ   <= halfCnt;
        fixedQ <= 1'b0;
        if (halfCnt == CNT_W'(1)) begin
          stateQ <= ST_IDLE;
          doneQ  <= 1'b1;
        end
      end

      if (strb.clearAll) begin
        lanePtrQ <= '0;
        beatQ    <= '0;
      end else if (strb.accumLane) begin
        if (beatQ == LAST_BEAT) begin
          beatQ    <= '0;
          lanePtrQ <= lanePtrQ + CNT_W'(1);
        end else begin
          beatQ <= beatQ + BEAT_W'(1);
        end
      end
    end
  end

  assign busy = !isIdle;
  assign done = doneQ;

endmodule

// File: rtl/tree_red_dp.sv
module tree_red_dp
  import tree_red_pkg::*;
#(
  parameter int NUM_LANES = 10,
  parameter int IN_W      = 16,
  parameter int SUM_W     = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  red_strobe_t       strb,
  input  logic [IN_W-1:0]   wrData,
  input  logic [IN_W-1:0]   inData,
  output logic [SUM_W-1:0]  total
);

  logic [SUM_W-1:0] laneQ [NUM_LANES];
  logic [SUM_W-1:0] fixVal;
  logic [SUM_W-1:0] wrExt;
  logic [SUM_W-1:0] inExt;

  assign wrExt = SUM_W'(wrData);
  assign inExt = SUM_W'(inData);

  // leftover lane picked for the odd-count correction
  always_comb begin
    fixVal = '0;
    for (int j = 0; j < NUM_LANES; j++) begin
      if (j == int'(strb.laneSel)) fixVal = laneQ[j];
    end
  end

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    logic [SUM_W-1:0] regQ;
    logic [SUM_W-1:0] partner;
    logic [SUM_W-1:0] nxt;
    logic             selHere;

    assign selHere  = (int'(strb.laneSel) == i);
    assign laneQ[i] = regQ;

    always_comb begin
      partner = '0;
      for (int j = 0; j < NUM_LANES; j++) begin
        if (j == i + int'(strb.foldHalf)) partner = laneQ[j];
      end
    end

    always_comb begin
      nxt = regQ;
      if (strb.clearAll) begin
        nxt = '0;
      end else if (strb.foldStep && (i < int'(strb.foldHalf))) begin
        nxt = regQ + partner;
      end else if (strb.fixStep && (i == 0)) begin
        nxt = regQ + fixVal;
      end else if (strb.loadLane && selHere) begin
        nxt = wrExt;
      end else if (strb.accumLane && selHere) begin
        nxt = regQ + inExt;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regQ <= '0;
      else       regQ <= nxt;
    end
  end

  assign total = laneQ[0];

endmodule

// File: rtl/tree_red_acc.sv
module tree_red_acc
  import tree_red_pkg::*;
#(
  parameter int NUM_LANES = 10,
  parameter int IN_W      = 16,
  parameter int PART_LEN  = 4,
  localparam int IDX_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
  localparam int SUM_W    = IN_W + $clog2(NUM_LANES * PART_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [IN_W-1:0]  wrData,
  input  logic             clrLocal,
  input  logic             inValid,
  input  logic [IN_W-1:0]  inData,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic [SUM_W-1:0] total
);

  red_strobe_t strb;

  tree_red_ctrl #(
    .NUM_LANES (NUM_LANES),
    .PART_LEN  (PART_LEN),
    .IDX_W     (IDX_W)
  ) ctrlInst (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrIdx    (wrIdx),
    .clrLocal (clrLocal),
    .inValid  (inValid),
    .start    (start),
    .strb     (strb),
    .busy     (busy),
    .done     (done)
  );

  tree_red_dp #(
    .NUM_LANES (NUM_LANES),
    .IN_W      (IN_W),
    .SUM_W     (SUM_W)
  ) dpInst (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .inData (inData),
    .total  (total)
  );

endmodule

// File: rtl/tree_red_chk.sv
module tree_red_chk #(
  parameter int NUM_LANES = 10,
  parameter int SUM_W     = 22
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             wrEn,
  input logic             inValid,
  input logic             clrLocal,
  input logic             busy,
  input logic             done,
  input logic [SUM_W-1:0] total
);

  localparam int MAX_RUN = 2 * $clog2(NUM_LANES);

  logic [7:0] runQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     runQ <= '0;
    else if (busy) runQ <= runQ + 8'd1;
    else           runQ <= '0;
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R5
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R4
  run_ends_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !start) |=> (busy || done));

  // R4
  run_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(runQ) <= MAX_RUN);

  // R3
  no_shrink_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (total >= $past(total)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start && !clrLocal && !wrEn && !inValid) |=> $stable(total));

endmodule

bind tree_red_acc tree_red_chk #(
  .NUM_LANES (NUM_LANES),
  .SUM_W     (SUM_W)
) chkInst (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .wrEn     (wrEn),
  .inValid  (inValid),
  .clrLocal (clrLocal),
  .busy     (busy),
  .done     (done),
  .total    (total)
);

// File: tb/tb_tree_red_acc.sv
`timescale 1ns/1ps
module tb_tree_red_acc;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  // main instance: 10 lanes, 16-bit inputs, 4 beats per lane
  logic        wrEn = 0, clrLocal = 0, inValid = 0, start = 0;
  logic [3:0]  wrIdx = '0;
  logic [15:0] wrData = '0, inData = '0;
  logic        busy, done;
  logic [21:0] total;

  tree_red_acc #(.NUM_LANES(10), .IN_W(16), .PART_LEN(4)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .clrLocal(clrLocal), .inValid(inValid), .inData(inData), .start(start),
    .busy(busy), .done(done), .total(total));

  // odd instance: 7 lanes, 2 beats per lane
  logic        wrEn7 = 0, start7 = 0, idle7 = 0;
  logic [2:0]  wrIdx7 = '0;
  logic [15:0] wrData7 = '0, zero7 = '0;
  logic        busy7, done7;
  logic [19:0] total7;

  tree_red_acc #(.NUM_LANES(7), .IN_W(16), .PART_LEN(2)) dutOdd (
    .clk(clk), .rstN(rstN), .wrEn(wrEn7), .wrIdx(wrIdx7), .wrData(wrData7),
    .clrLocal(idle7), .inValid(idle7), .inData(zero7), .start(start7),
    .busy(busy7), .done(done7), .total(total7));

  int nChecks = 0;
  int nErrors = 0;

  localparam logic [15:0] VEC [4][10] = '{
    '{16'd1, 16'd2, 16'd3, 16'd4, 16'd5, 16'd6, 16'd7, 16'd8, 16'd9, 16'd10},
    '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF,
      16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF},
    '{16'h8000, 16'd0, 16'h8000, 16'd0, 16'h8000,
      16'd0, 16'h8000, 16'd0, 16'h8000, 16'd0},
    '{16'd7, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd3}
  };
  localparam logic [21:0] EXP [4] = '{22'd55, 22'd655350, 22'd163840, 22'd10};

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic writeLane(input int idx, input int val);
    wrEn = 1; wrIdx = 4'(idx); wrData = 16'(val);
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic pulse(ref logic sig);
    sig = 1;
    @(negedge clk);
    sig = 0;
  endtask

  // start, then count falling edges until done; lat = 0 if it never comes
  task automatic runTree(output int lat, output logic [21:0] res);
    lat = 0;
    res = '0;
    start = 1;
    @(negedge clk);
    start = 0;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (done) begin
        lat = k;
        res = total;
        break;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    int lat;
    logic [21:0] res;

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "busy in reset", busy, 0);
    check("R1", "done in reset", done, 0);
    rstN = 1;
    @(negedge clk);
    check("R1", "busy after reset", busy, 0);
    check("R1", "total after reset", total, 0);

    // table of vectors: R3 sums, R4 schedule, R5 pulse
    for (int v = 0; v < 4; v++) begin
      for (int i = 0; i < 10; i++) writeLane(i, VEC[v][i]);
      runTree(lat, res);
      check("R4", $sformatf("latency vec%0d", v), lat, 4);
      check("R3", $sformatf("total vec%0d", v), res, EXP[v]);
      @(negedge clk);
      check("R5", "done drops", done, 0);
      check("R5", "busy low after", busy, 0);
    end

    // R10 idle hold
    repeat (5) @(negedge clk);
    check("R10", "total holds idle", total, EXP[3]);

    // R5 busy during run
    for (int i = 0; i < 10; i++) writeLane(i, i + 1);
    start = 1;
    @(negedge clk);
    start = 0;
    @(negedge clk);
    check("R5", "busy after start", busy, 1);
    // R6: every input while busy
    wrEn = 1; wrIdx = 0; wrData = 16'd1000; start = 1;
    inValid = 1; inData = 16'd77; clrLocal = 1;
    @(negedge clk);
    wrEn = 0; start = 0; inValid = 0; clrLocal = 0;
    lat = 0;
    for (int k = 3; k <= 12; k++) begin
      if (done && lat == 0) begin
        lat = k - 1;
        res = total;
      end
      if (done && lat != 0 && k - 1 != lat) check("R6", "second done", 1, 0);
      @(negedge clk);
    end
    check("R6", "latency with busy inputs", lat, 4);
    check("R6", "total with busy inputs", res, 55);
    check("R6", "busy not restarted", busy, 0);

    // R7 clear
    for (int i = 0; i < 10; i++) writeLane(i, 16'hFFFF);
    pulse(clrLocal);
    runTree(lat, res);
    check("R7", "total after clear", res, 0);

    // R7 priority: clrLocal beats wrEn in the same cycle
    writeLane(2, 40);
    wrEn = 1; wrIdx = 4; wrData = 16'd9; clrLocal = 1;
    @(negedge clk);
    wrEn = 0; clrLocal = 0;
    runTree(lat, res);
    check("R7", "clear wins over write", res, 0);

    // R2 overwrite and last lane
    pulse(clrLocal);
    writeLane(3, 5);
    writeLane(3, 9);
    writeLane(9, 1);
    runTree(lat, res);
    check("R2", "overwrite total", res, 10);

    // R8 stream: 1..40 then an extra beat
    pulse(clrLocal);
    for (int b = 0; b < 41; b++) begin
      inValid = 1;
      inData = (b < 40) ? 16'(b + 1) : 16'd1000;
      @(negedge clk);
    end
    inValid = 0;
    runTree(lat, res);
    check("R8", "stream total extra ignored", res, 820);

    // R8 contiguous grouping: 4 beats stay in lane 0
    pulse(clrLocal);
    for (int b = 0; b < 4; b++) begin
      inValid = 1; inData = 16'd5;
      @(negedge clk);
    end
    inValid = 0;
    writeLane(0, 0);
    runTree(lat, res);
    check("R8", "first partition in lane0", res, 0);

    // R8 fifth beat moves to lane 1
    pulse(clrLocal);
    for (int b = 0; b < 5; b++) begin
      inValid = 1; inData = 16'd5;
      @(negedge clk);
    end
    inValid = 0;
    writeLane(0, 0);
    runTree(lat, res);
    check("R8", "fifth beat in lane1", res, 5);

    // R9 odd lane count
    for (int i = 0; i < 7; i++) begin
      wrEn7 = 1; wrIdx7 = 3'(i); wrData7 = 16'(1 << i);
      @(negedge clk);
    end
    wrEn7 = 0;
    start7 = 1;
    @(negedge clk);
    start7 = 0;
    lat = 0;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (done7) begin
        lat = k;
        check("R9", "odd total", total7, 127);
        break;
      end
    end
    check("R9", "odd latency", lat, 4);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule